// File: doc/BRIEF.md
# Overvoltage Protection Sequencer

This block supervises the output of a multi-phase voltage regulator for overvoltage. Each clock cycle it chooses a trip level from the supply state, the enable state and the soft-start state. It compares the digitized sense or differential voltage against that level. Every voltage arrives as an unsigned millivolt code.

When a trip is detected, the block latches a fault and turns on the crowbar drive. It then commands every phase output low. The outputs stay low until the sense voltage has dropped below a release level and the differential voltage has come down to the VID setpoint. At that point the phases are released to high-impedance. If the overvoltage returns, the pull-low starts again. This repeats for every recurrence until a hard clear.

The analog comparators, the crowbar device and the PWM modulator sit outside the block.

Top module: `ovp_sequencer`

## Requirements
- R1: With reset held and for the cycle after it, every phase mode reads 00 (normal), and crowbar and fault both read 0.
- R2: When aux_ok is 1 and supply_ok is 0, a trip occurs only when vsen_mv is strictly above 1800. A value of exactly 1800 does not trip.
- R3: When supply_ok is 1 and neither enable_ok together with ss_active nor enable_ok together with ss_done holds, a trip occurs only when vdiff_mv is strictly above 1700.
- R4: When supply_ok, enable_ok and ss_active are 1 (and ss_done is 0), the trip level on vdiff_mv is the larger of 1700 and vid_mv+200.
- R5: When supply_ok, enable_ok and ss_done are 1, the trip level on vdiff_mv is vid_mv+200. The same level applies on vdiff_mv whenever a fault is latched and supply_ok is 1.
- R6: Once a trip is detected, every phase mode reads 01 (forced low), and crowbar and fault read 1. This takes effect exactly two clock edges after the input that caused it.
- R7: After a trip, the phases stay at 01 until two things have happened: vsen_mv is below 600 (if supply_ok is 1) or below 1500 (if supply_ok is 0), and vdiff_mv has fallen to vid_mv or lower. The phases then read 10 (high-impedance).
- R8: While the phases read 10, a renewed overvoltage against the current trip level forces them back to 01. This holds for every recurrence.
- R9: A latched fault and the crowbar persist through changes of vid_mv and through enable_ok falling. They clear only on a rising enable_ok, a falling supply_ok, aux_ok low, or reset. The phases then read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_ok | input | 1 | Supply above the auxiliary detection floor |
| supply_ok | input | 1 | Supply fully valid |
| enable_ok | input | 1 | Enable conditions met |
| ss_active | input | 1 | Soft-start in progress |
| ss_done | input | 1 | Soft-start completed |
| vid_mv | input | 12 | VID setpoint, millivolts |
| vsen_mv | input | 12 | Sense voltage, millivolts |
| vdiff_mv | input | 12 | Differential voltage, millivolts |
| pwm_mode | output | NPHASE x 2 | Per-phase mode: 00 normal, 01 forced low, 10 high-impedance |
| crowbar | output | 1 | Crowbar drive |
| fault | output | 1 | Latched overvoltage fault |

## Verification
The assertions take two things for granted about the inputs. First, supply_ok never reads 1 while aux_ok reads 0. Second, ss_active and ss_done are never both 1. The stimulus honours both by deriving the flags for each mode from a single mode choice. It also applies every trial from a reset, with base voltages well below any trip level, so that stale registered comparisons cannot cause a trip of their own. Threshold sweeps place the probe one code below, at, and one code above each computed level across a range of VID codes. The recurrence and clear scenarios hold the sense voltage inside its release window, so that only the intended input drives each transition.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    localparam int MV_W  = 12;
    localparam int LVL_W = MV_W + 1;

    localparam logic [LVL_W-1:0] AUX_TRIP_MV  = LVL_W'(1800);
    localparam logic [LVL_W-1:0] PRE_EN_MV    = LVL_W'(1700);
    localparam logic [LVL_W-1:0] VID_OFS_MV   = LVL_W'(200);
    localparam logic [LVL_W-1:0] REL_VALID_MV = LVL_W'(600);
    localparam logic [LVL_W-1:0] REL_AUX_MV   = LVL_W'(1500);

    typedef enum logic [1:0] {
        PWM_RUN   = 2'b00,
        PWM_SINK  = 2'b01,
        PWM_FLOAT = 2'b10
    } pwm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PULL  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FLOAT = 2'd3
    } ovp_state_e;

    typedef struct packed {
        logic ov_hit;
        logic rel_ok;
        logic at_vid;
        logic clr;
    } cmp_flags_t;

    function automatic logic [LVL_W-1:0] vid_plus_margin(input logic [MV_W-1:0] vid);
        return {1'b0, vid} + VID_OFS_MV;
    endfunction

    function automatic logic [LVL_W-1:0] valid_trip_level(
        input logic             tripped,
        input logic             enable_ok,
        input logic             ss_active,
        input logic             ss_done,
        input logic [MV_W-1:0]  vid
    );
        logic [LVL_W-1:0] vm;
        vm = vid_plus_margin(vid);
        if (tripped || (enable_ok && ss_done))
            return vm;
        else if (enable_ok && ss_active)
            return (vm > PRE_EN_MV) ? vm : PRE_EN_MV;
        else
            return PRE_EN_MV;
    endfunction

    function automatic pwm_mode_e state_to_mode(input ovp_state_e st);
        case (st)
            ST_PULL, ST_HOLD: return PWM_SINK;
            ST_FLOAT:         return PWM_FLOAT;
            default:          return PWM_RUN;
        endcase
    endfunction

endpackage

// File: rtl/ovp_compare.sv
module ovp_compare
    import ovp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             aux_ok,
    input  logic             supply_ok,
    input  logic             enable_ok,
    input  logic             ss_active,
    input  logic             ss_done,
    input  logic             tripped,
    input  logic [MV_W-1:0]  vid_mv,
    input  logic [MV_W-1:0]  vsen_mv,
    input  logic [MV_W-1:0]  vdiff_mv,
    output cmp_flags_t       flags
);

    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] rel_level;
    logic             sup_q;
    logic             en_q;
    cmp_flags_t       flags_d;

    always_comb begin
        level     = valid_trip_level(tripped, enable_ok, ss_active, ss_done, vid_mv);
        rel_level = supply_ok ? REL_VALID_MV : REL_AUX_MV;

        if (supply_ok)
            flags_d.ov_hit = ({1'b0, vdiff_mv} > level);
        else
            flags_d.ov_hit = aux_ok && ({1'b0, vsen_mv} > AUX_TRIP_MV);

        flags_d.rel_ok = ({1'b0, vsen_mv} < rel_level);
        flags_d.at_vid = (vdiff_mv <= vid_mv);
        flags_d.clr    = ~aux_ok | (sup_q & ~supply_ok) | (~en_q & enable_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            sup_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            flags <= flags_d;
            sup_q <= supply_ok;
            en_q  <= enable_ok;
        end
    end

    // R2: no trip can be flagged for a cycle in which the auxiliary supply was absent
    a_r2_no_trip_without_aux: assert property (@(posedge clk) disable iff (rst)
        !$past(aux_ok) |-> !flags.ov_hit);

    // R9: a rising enable always raises the clear request one edge later
    a_r9_enable_rise_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(enable_ok) |=> flags.clr);

endmodule

// File: rtl/ovp_fsm.sv
module ovp_fsm
    import ovp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmp_flags_t  flags,
    output ovp_state_e  state,
    output logic        crowbar
);

    ovp_state_e state_d;

    always_comb begin
        state_d = state;
        if (flags.clr) begin
            state_d = ST_RUN;
        end else begin
            case (state)
                ST_RUN:   if (flags.ov_hit) state_d = ST_PULL;
                ST_PULL:  if (flags.rel_ok) state_d = ST_HOLD;
                ST_HOLD:  if (flags.at_vid) state_d = ST_FLOAT;
                ST_FLOAT: if (flags.ov_hit) state_d = ST_PULL;
                default:  state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            crowbar <= 1'b0;
        end else begin
            state <= state_d;
            if (flags.clr)
                crowbar <= 1'b0;
            else if (flags.ov_hit && (state == ST_RUN || state == ST_FLOAT))
                crowbar <= 1'b1;
        end
    end

    // R6: a trip seen in normal operation starts the pull-low on the next edge
    a_r6_trip_starts_pull: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && flags.ov_hit && !flags.clr) |=> (state == ST_PULL && crowbar));

    // R8: a recurrence while floating re-arms the pull-low
    a_r8_rearm_from_float: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLOAT && flags.ov_hit && !flags.clr) |=> state == ST_PULL);

    // R9: crowbar is only dropped by a clear request
    a_r9_crowbar_latched: assert property (@(posedge clk) disable iff (rst)
        (crowbar && !flags.clr) |=> crowbar);

    // R7: the float state is entered only from hold once the setpoint is reached
    a_r7_float_entry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLOAT && $past(state) != ST_FLOAT) |->
            ($past(state) == ST_HOLD && $past(flags.at_vid)));

endmodule

// File: rtl/ovp_pwm_drive.sv
module ovp_pwm_drive
    import ovp_pkg::*;
#(
    parameter int NPHASE = 4
) (
    input  ovp_state_e               state,
    output logic [NPHASE-1:0][1:0]   pwm_mode
);

    for (genvar ph = 0; ph < NPHASE; ph++) begin : g_phase
        always_comb pwm_mode[ph] = state_to_mode(state);
    end

endmodule

// File: rtl/ovp_sequencer.sv
module ovp_sequencer
    import ovp_pkg::*;
#(
    parameter int NPHASE = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    aux_ok,
    input  logic                    supply_ok,
    input  logic                    enable_ok,
    input  logic                    ss_active,
    input  logic                    ss_done,
    input  logic [MV_W-1:0]         vid_mv,
    input  logic [MV_W-1:0]         vsen_mv,
    input  logic [MV_W-1:0]         vdiff_mv,
    output logic [NPHASE-1:0][1:0]  pwm_mode,
    output logic                    crowbar,
    output logic                    fault
);

    cmp_flags_t  flags;
    ovp_state_e  state;
    logic        tripped;

    assign tripped = (state != ST_RUN);
    assign fault   = tripped;

    ovp_compare u_compare (
        .clk       (clk),
        .rst       (rst),
        .aux_ok    (aux_ok),
        .supply_ok (supply_ok),
        .enable_ok (enable_ok),
        .ss_active (ss_active),
        .ss_done   (ss_done),
        .tripped   (tripped),
        .vid_mv    (vid_mv),
        .vsen_mv   (vsen_mv),
        .vdiff_mv  (vdiff_mv),
        .flags     (flags)
    );

    ovp_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .state   (state),
        .crowbar (crowbar)
    );

    ovp_pwm_drive #(.NPHASE(NPHASE)) u_drive (
        .state    (state),
        .pwm_mode (pwm_mode)
    );

    // R6: any phase leaving normal mode implies the crowbar is driven
    a_r6_drive_with_crowbar: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode[0] != PWM_RUN) |-> crowbar);

    // R1: the cycle after reset shows normal operation with nothing latched
    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (!crowbar && !fault && pwm_mode[0] == PWM_RUN));

endmodule

// File: tb/test_ovp_sequencer.sv
module test_ovp_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NPH        = 3;
    localparam logic [1:0] M_RUN = 2'b00, M_LOW = 2'b01, M_HIZ = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic aux_ok = 1'b1, supply_ok = 1'b1, enable_ok = 1'b0;
    logic ss_active = 1'b0, ss_done = 1'b0;
    logic [11:0] vid_mv = 12'd1200, vsen_mv = 12'd0, vdiff_mv = 12'd0;
    logic [NPH-1:0][1:0] pwm_mode;
    logic crowbar, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovp_sequencer #(.NPHASE(NPH)) i_ovp_sequencer (
        .clk(clk), .rst(rst), .aux_ok(aux_ok), .supply_ok(supply_ok),
        .enable_ok(enable_ok), .ss_active(ss_active), .ss_done(ss_done),
        .vid_mv(vid_mv), .vsen_mv(vsen_mv), .vdiff_mv(vdiff_mv),
        .pwm_mode(pwm_mode), .crowbar(crowbar), .fault(fault)
    );

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [1:0] emode,
                              input logic ecb, input logic eflt);
        logic ok;
        ok = (crowbar === ecb) && (fault === eflt);
        for (int p = 0; p < NPH; p++)
            if (pwm_mode[p] !== emode) ok = 1'b0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: pwm=%b crowbar=%b fault=%b, expected pwm=%b crowbar=%b fault=%b",
                     req, pwm_mode, crowbar, fault, {NPH{emode}}, ecb, eflt);
        end
    endtask

    task automatic set_mode(input int m);
        // 0 aux only, 1 valid pre-enable, 2 soft-start active, 3 soft-start done
        aux_ok    = 1'b1;
        supply_ok = (m != 0);
        enable_ok = (m >= 2);
        ss_active = (m == 2);
        ss_done   = (m == 3);
    endtask

    task automatic trial(input string req, input int m, input logic [11:0] vid,
                         input logic [11:0] vsen_p, input logic [11:0] vdiff_p,
                         input logic exp_trip);
        rst = 1'b1;
        set_mode(m);
        vid_mv = vid; vsen_mv = 12'd0; vdiff_mv = 12'd0;
        settle(2);
        rst = 1'b0;
        settle(3);
        vsen_mv = vsen_p; vdiff_mv = vdiff_p;
        settle(2);
        expect_out(req, exp_trip ? M_LOW : M_RUN, exp_trip, exp_trip);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int thr;
        // R1: reset state
        set_mode(3);
        vdiff_mv = 12'd3000;
        settle(2);
        expect_out("R1 during reset", M_RUN, 1'b0, 1'b0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        expect_out("R1 after reset", M_RUN, 1'b0, 1'b0);

        // R2: auxiliary-supply sweep on vsen
        for (int d = -2; d <= 2; d++)
            trial("R2 aux threshold", 0, 12'd1200, 12'(1800 + d), 12'd0, (1800 + d) > 1800);

        // R3: pre-enable level, with and without enable
        for (int d = -1; d <= 1; d++) begin
            trial("R3 pre-enable", 1, 12'd1600, 12'd1000, 12'(1700 + d), (1700 + d) > 1700);
            trial("R3 pre-enable high vid", 1, 12'd2000, 12'd1000, 12'(1700 + d), (1700 + d) > 1700);
        end

        // R4 and R5: soft-start and post-soft-start sweeps over VID
        for (int v = 800; v <= 1800; v += 100) begin
            thr = (v + 200 > 1700) ? v + 200 : 1700;
            for (int d = -1; d <= 1; d++)
                trial("R4 soft-start level", 2, 12'(v), 12'd1000, 12'(thr + d), (thr + d) > thr);
            for (int d = -1; d <= 1; d++)
                trial("R5 done level", 3, 12'(v), 12'd1000, 12'(v + 200 + d), d > 0);
        end

        // R6/R7/R8: sequence with valid supply
        trial("R6 trip", 3, 12'd1200, 12'd1401, 12'd1401, 1'b1);
        vdiff_mv = 12'd1300; vsen_mv = 12'd700;
        settle(4);
        expect_out("R7 low while vsen above 600", M_LOW, 1'b1, 1'b1);
        vsen_mv = 12'd599;
        settle(4);
        expect_out("R7 low while vdiff above vid", M_LOW, 1'b1, 1'b1);
        vdiff_mv = 12'd1200;
        settle(2);
        expect_out("R7 float at vid", M_HIZ, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            vdiff_mv = 12'd1400;
            settle(3);
            expect_out("R8 stays float at level", M_HIZ, 1'b1, 1'b1);
            vdiff_mv = 12'd1401;
            settle(2);
            expect_out("R8 recurrence pulls low", M_LOW, 1'b1, 1'b1);
            vdiff_mv = 12'd1200;
            settle(3);
            expect_out("R8 floats again", M_HIZ, 1'b1, 1'b1);
        end

        // R9: persistence and clears
        vid_mv = 12'd1000;
        settle(4);
        expect_out("R9 vid change keeps fault", M_HIZ, 1'b1, 1'b1);
        enable_ok = 1'b0;
        settle(4);
        expect_out("R9 enable fall keeps fault", M_HIZ, 1'b1, 1'b1);
        enable_ok = 1'b1; vid_mv = 12'd1200;
        settle(2);
        expect_out("R9 enable rise clears", M_RUN, 1'b0, 1'b0);

        trial("R6 trip before supply fall", 3, 12'd1200, 12'd1000, 12'd1500, 1'b1);
        supply_ok = 1'b0; vsen_mv = 12'd1800;
        settle(2);
        expect_out("R9 supply fall clears", M_RUN, 1'b0, 1'b0);
        settle(3);
        expect_out("R9 stays clear", M_RUN, 1'b0, 1'b0);

        // R7/R8 with auxiliary supply, then aux loss clear
        trial("R6 aux trip", 0, 12'd1200, 12'd1801, 12'd1500, 1'b1);
        vsen_mv = 12'd1600;
        settle(4);
        expect_out("R7 aux low above 1500", M_LOW, 1'b1, 1'b1);
        vsen_mv = 12'd1499;
        settle(4);
        expect_out("R7 aux low above vid", M_LOW, 1'b1, 1'b1);
        vdiff_mv = 12'd1100;
        settle(2);
        expect_out("R7 aux float", M_HIZ, 1'b1, 1'b1);
        vsen_mv = 12'd1801;
        settle(2);
        expect_out("R8 aux recurrence", M_LOW, 1'b1, 1'b1);
        aux_ok = 1'b0; vsen_mv = 12'd0;
        settle(2);
        expect_out("R9 aux loss clears", M_RUN, 1'b0, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule